// File: doc/BRIEF.md
# Pen Contact Debounce Detector

This block cleans up the raw contact comparator output of a resistive touch panel. The raw level passes through a synchronizer. A run counter then advances only on clock edges that carry an ADC clock tick. The filtered contact level flips once the synchronized input has disagreed with it for a whole window of 2^N ticks, where N is a 4-bit debounce exponent. Each flip produces a one-cycle touch or release pulse. Each flip also sets a sticky flag that an interrupt controller can sample and later clear.

An exponent of zero makes the window a single tick, so the filter is in effect bypassed. This is the setting to use while the pen is down if loss of contact has to be caught reliably. A detection enable gates the whole function. While it is low, the filtered level is held at "no contact" and no pulse or flag can be produced.

Top module: `pen_contact_filter`

## Requirements
- R1: After reset, `pen_level` is 0 (no contact), both event pulses are 0 and both sticky flags are 0.
- R2: `pen_raw` passes a two-stage synchronizer. With `adc_tick` held high and `det_en` high, a change on `pen_raw` held steady shows on `pen_level` on the (2^N + 2)-th rising clock edge after the change, where N = `dbc_exp`. It has not shown on the edge before that.
- R3: The run counter restarts whenever a ticked edge sees the synchronized input equal to `pen_level`. A single-cycle return to the filtered value therefore delays the flip by a full new window.
- R4: The run counter advances only on edges where `adc_tick` is 1. With `adc_tick` low, `pen_level` never changes while `det_en` is high.
- R5: With `dbc_exp` = 0 the window is one tick, so a change is accepted on the first ticked edge after synchronization.
- R6: `pen_down_pulse` is high for exactly one cycle, in the cycle in which `pen_level` has just gone from 0 to 1. `pen_up_pulse` behaves the same way for a change from 1 to 0. The two pulses are never high together.
- R7: `stat_down` and `stat_up` are set together with their pulses. They hold until a cycle with `stat_clr` high and read 0 on the following cycle. If a set and a clear arrive in the same cycle, the set wins.
- R8: While `det_en` is 0, `pen_level` is forced to 0 on the next edge and the run counter is cleared. No pulse and no flag is produced, including when the level is dropped from 1. After `det_en` returns to 1 with a steady contact, the flip takes a full 2^N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Contact detection enable |
| dbc_exp | input | 4 | Debounce exponent N, window = 2^N ticks |
| adc_tick | input | 1 | One-cycle ADC clock tick in the block clock domain |
| pen_raw | input | 1 | Raw contact comparator level (1 = contact) |
| stat_clr | input | 1 | Clears both sticky flags (status read) |
| pen_level | output | 1 | Filtered contact level |
| pen_down_pulse | output | 1 | One-cycle contact event |
| pen_up_pulse | output | 1 | One-cycle release event |
| stat_down | output | 1 | Sticky contact flag |
| stat_up | output | 1 | Sticky release flag |

## Verification
The bench sweeps the exponent over 0 to 10 and also 15. For each value it times both the press and the release against 2^N + 2 edges, so an off-by-one window or a missing synchronizer stage shows up as a level one edge early or late. A one-cycle dip in the middle of a window catches a counter that keeps counting instead of restarting, because such a counter flips early. Tick-gated counting and toggling of the enable catch a counter that runs on untied edges, and a disable path that leaks a release pulse or flag.

// File: rtl/pen_dbc_pkg.sv
`timescale 1ns/1ps
package pen_dbc_pkg;

  typedef enum logic {
    PEN_AWAY  = 1'b0,
    PEN_TOUCH = 1'b1
  } pen_state_e;

  // Window length in ticks for a given exponent.
  function automatic int unsigned dbc_span(input int unsigned e);
    return 32'd1 << e;
  endfunction

endpackage

// File: rtl/pen_sync.sv
`timescale 1ns/1ps
module pen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pen_window.sv
`timescale 1ns/1ps
module pen_window
  import pen_dbc_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             raw_s,
  input  logic [EXP_W-1:0] exp_n,
  output logic             level,
  output logic             down_p,
  output logic             up_p,
  output logic             take_dn,
  output logic             take_up,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] span
);
  pen_state_e       level_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ;
  logic             reach;

  assign span    = CNT_W'(dbc_span(32'(exp_n)));
  assign differ  = en && (raw_s != logic'(level_q));
  assign reach   = differ && tick && ((cnt_q + CNT_W'(1)) == span);
  assign take_dn = reach && (level_q == PEN_AWAY);
  assign take_up = reach && (level_q == PEN_TOUCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= PEN_AWAY;
      cnt_q   <= '0;
      down_p  <= 1'b0;
      up_p    <= 1'b0;
    end else begin
      down_p <= take_dn;
      up_p   <= take_up;
      if (!en) begin
        level_q <= PEN_AWAY;
        cnt_q   <= '0;
      end else if (tick) begin
        if (!differ) begin
          cnt_q <= '0;
        end else if (reach) begin
          level_q <= (level_q == PEN_AWAY) ? PEN_TOUCH : PEN_AWAY;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign level   = logic'(level_q);
  assign run_cnt = cnt_q;
endmodule

// File: rtl/pen_flags.sv
`timescale 1ns/1ps
module pen_flags #(
  parameter int N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_v,
  input  logic               clr,
  output logic [N_FLAGS-1:0] flag_v
);
  generate
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_v[i] <= 1'b0;
        else        flag_v[i] <= set_v[i] | (flag_v[i] & ~clr);
      end
    end
  endgenerate
endmodule

// File: rtl/pen_contact_filter.sv
`timescale 1ns/1ps
module pen_contact_filter #(
  parameter int EXP_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic [EXP_W-1:0] dbc_exp,
  input  logic             adc_tick,
  input  logic             pen_raw,
  input  logic             stat_clr,
  output logic             pen_level,
  output logic             pen_down_pulse,
  output logic             pen_up_pulse,
  output logic             stat_down,
  output logic             stat_up
);
  localparam int CNT_W = 1 << EXP_W;

  logic             raw_s;
  logic             take_dn;
  logic             take_up;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] span;
  logic [1:0]       flag_v;

  pen_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pen_raw), .q(raw_s)
  );

  pen_window #(.EXP_W(EXP_W), .CNT_W(CNT_W)) win_i (
    .clk(clk), .rst_n(rst_n), .en(det_en), .tick(adc_tick),
    .raw_s(raw_s), .exp_n(dbc_exp), .level(pen_level),
    .down_p(pen_down_pulse), .up_p(pen_up_pulse),
    .take_dn(take_dn), .take_up(take_up),
    .run_cnt(run_cnt), .span(span)
  );

  pen_flags #(.N_FLAGS(2)) flags_i (
    .clk(clk), .rst_n(rst_n), .set_v({take_up, take_dn}),
    .clr(stat_clr), .flag_v(flag_v)
  );

  assign stat_down = flag_v[0];
  assign stat_up   = flag_v[1];
endmodule

// File: rtl/pen_contact_filter_chk.sv
`timescale 1ns/1ps
module pen_contact_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_en,
  input logic             adc_tick,
  input logic             stat_clr,
  input logic             pen_level,
  input logic             pen_down_pulse,
  input logic             pen_up_pulse,
  input logic             stat_down,
  input logic             stat_up,
  input logic [CNT_W-1:0] run_cnt,
  input logic [CNT_W-1:0] span
);
  // R2: counter never reaches the window length
  a_r2_cnt_below_span: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < span);

  // R4: no tick, no level change while enabled
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_tick && det_en) |=> $stable(pen_level));

  // R6: pulses are single-cycle and tied to level edges
  a_r6_down_single: assert property (@(posedge clk) disable iff (!rst_n)
    pen_down_pulse |=> !pen_down_pulse);
  a_r6_up_single: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up_pulse |=> !pen_up_pulse);
  a_r6_down_edge: assert property (@(posedge clk) disable iff (!rst_n)
    pen_down_pulse |-> (pen_level && !$past(pen_level)));
  a_r6_up_edge: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up_pulse |-> (!pen_level && $past(pen_level)));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pen_down_pulse && pen_up_pulse));

  // R7: flags follow pulses and stick until cleared
  a_r7_down_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    pen_down_pulse |-> stat_down);
  a_r7_up_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up_pulse |-> stat_up);
  a_r7_down_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_down && !stat_clr) |=> stat_down);

  // R8: disabled detection is silent
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (!pen_level && !pen_down_pulse && !pen_up_pulse));
endmodule

bind pen_contact_filter pen_contact_filter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .adc_tick(adc_tick),
  .stat_clr(stat_clr), .pen_level(pen_level),
  .pen_down_pulse(pen_down_pulse), .pen_up_pulse(pen_up_pulse),
  .stat_down(stat_down), .stat_up(stat_up),
  .run_cnt(run_cnt), .span(span)
);

// File: tb/pen_contact_filter_tb.sv
`timescale 1ns/1ps
module pen_contact_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       det_en = 1'b1;
  logic [3:0] dbc_exp = 4'd0;
  logic       adc_tick = 1'b1;
  logic       pen_raw = 1'b0;
  logic       stat_clr = 1'b0;
  logic       pen_level, pen_down_pulse, pen_up_pulse, stat_down, stat_up;

  int errs = 0;
  int total = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pen_contact_filter dut_i (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .dbc_exp(dbc_exp),
    .adc_tick(adc_tick), .pen_raw(pen_raw), .stat_clr(stat_clr),
    .pen_level(pen_level), .pen_down_pulse(pen_down_pulse),
    .pen_up_pulse(pen_up_pulse), .stat_down(stat_down), .stat_up(stat_up)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic clear_flags();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check("R7", "down flag cleared", stat_down, 0);
    check("R7", "up flag cleared", stat_up, 0);
  endtask

  // Drive a steady new level and time the filtered response: 2^e + 2 edges.
  task automatic timed_edge(input logic nv, input int e, input string req);
    int w;
    w = 1 << e;
    pen_raw = nv;
    repeat (w + 1) @(negedge clk);
    check(req, "level before window end", pen_level, !nv);
    @(negedge clk);
    check(req, "level at window end", pen_level, nv);
    check("R6", "pulse on flip", nv ? pen_down_pulse : pen_up_pulse, 1);
    check("R6", "other pulse quiet", nv ? pen_up_pulse : pen_down_pulse, 0);
    @(negedge clk);
    check("R6", "pulse one cycle", nv ? pen_down_pulse : pen_up_pulse, 0);
    check("R7", "flag set", nv ? stat_down : stat_up, 1);
    @(negedge clk);
    check("R7", "flag sticks", nv ? stat_down : stat_up, 1);
    clear_flags();
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "level", pen_level, 0);
    check("R1", "down pulse", pen_down_pulse, 0);
    check("R1", "up pulse", pen_up_pulse, 0);
    check("R1", "down flag", stat_down, 0);
    check("R1", "up flag", stat_up, 0);

    // R2 / R5 exponent sweep, press and release
    for (int e = 0; e <= 11; e++) begin
      int ex;
      ex = (e == 11) ? 15 : e;
      dbc_exp = 4'(ex);
      timed_edge(1'b1, ex, (ex == 0) ? "R5" : "R2");
      timed_edge(1'b0, ex, (ex == 0) ? "R5" : "R2");
    end

    // R3 one-cycle dip restarts the window (W = 8)
    dbc_exp = 4'd3;
    pen_raw = 1'b1;
    repeat (6) @(negedge clk);
    pen_raw = 1'b0;
    @(negedge clk);
    check("R3", "no flip before dip settles", pen_level, 0);
    timed_edge(1'b1, 3, "R3");
    timed_edge(1'b0, 3, "R3");

    // R4 counting only on ticks (W = 4)
    dbc_exp = 4'd2;
    adc_tick = 1'b0;
    pen_raw = 1'b1;
    repeat (10) @(negedge clk);
    check("R4", "no change without ticks", pen_level, 0);
    for (int i = 1; i <= 4; i++) begin
      adc_tick = 1'b1;
      @(negedge clk);
      adc_tick = 1'b0;
      check("R4", "level after tick count", pen_level, (i == 4) ? 1 : 0);
      repeat (2) @(negedge clk);
    end
    adc_tick = 1'b1;
    clear_flags();
    timed_edge(1'b0, 2, "R4");

    // R8 disable holds off detection, then full window after enable
    det_en = 1'b0;
    pen_raw = 1'b1;
    repeat (20) @(negedge clk);
    check("R8", "level while disabled", pen_level, 0);
    check("R8", "down flag while disabled", stat_down, 0);
    det_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "no flip before 4 ticks", pen_level, 0);
    @(negedge clk);
    check("R8", "flip after 4 ticks", pen_level, 1);
    @(negedge clk);
    clear_flags();
    det_en = 1'b0;
    @(negedge clk);
    check("R8", "level dropped by disable", pen_level, 0);
    check("R8", "no up pulse on disable", pen_up_pulse, 0);
    @(negedge clk);
    check("R8", "no up flag on disable", stat_up, 0);
    pen_raw = 1'b0;
    repeat (3) @(negedge clk);
    det_en = 1'b1;
    repeat (10) @(negedge clk);
    check("R8", "stays away after re-enable", pen_level, 0);

    // R7 set wins over clear
    dbc_exp = 4'd0;
    pen_raw = 1'b1;
    repeat (2) @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check("R7", "set beats clear", stat_down, 1);
    clear_flags();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule